// File: doc/BRIEF.md
# NRZI Line Encoder with Bit Stuffing

This block turns a serial bit stream into the transition-coded form used on a differential serial bus. A zero bit is sent as a change of line level and a one bit as no change. A long run of ones would leave the line without edges, so the encoder adds a forced zero after every six ones in a row. It drives a complementary pair of line outputs and an output enable. At the end of a packet it sends a short end marker: two bit times with both lines low, then one bit time of the idle level.

The upstream source starts a packet by raising `src_valid` while the encoder is idle. The source then presents one bit per clock and flags the final bit with `src_last`. The encoder pulls `src_ready` low for the one bit time before it inserts a stuffed bit. During that time the source holds its current bit. One clock equals one bit time. The bit accepted on a clock edge appears on the line during the following cycle.

Top module: `nrzi_stuff_tx`

## Requirements
- R1: After reset, `line_oe` is 0, `line_p` is 1, `line_n` is 0 and `src_ready` is 1.
- R2: While idle, the enable stays low and the line rests at the idle level (`line_p`=1, `line_n`=0). A packet starts only on a cycle where `src_valid` and `src_ready` are both high.
- R3: During a packet, a data bit of 0 is shown as a line level opposite to the previous bit time, and a 1 as the same level. The first bit is compared against the idle level (`line_p`=1).
- R4: A bit accepted on a clock edge is on the line during the next cycle, with `line_oe` high. Inside a packet a bit is taken on every cycle where `src_ready` is high, whatever the value of `src_valid`.
- R5: After six consecutive ones have appeared on the line, the next bit time carries an inserted zero, which is a level change. `src_ready` is low during the bit time that shows the sixth one, so the held bit follows the inserted zero.
- R6: The ones count clears on every zero and on every inserted bit, so a run of five ones followed by a zero gets no insertion.
- R7: Whenever at least one line output is high, `line_n` is the complement of `line_p`.
- R8: After the last bit, and after its inserted zero if one is due, the encoder drives exactly two cycles with both lines low and the enable high. It then drives one cycle of `line_p`=1, `line_n`=0 with the enable high, and after that lowers the enable.
- R9: The ones count and the line level restart at the beginning of every packet, so no run of ones carries over from the previous packet.
- R10: From the cycle after the last bit is accepted until the encoder is idle again, `src_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Source has a packet ready (sampled only while idle) |
| src_bit | input | 1 | Current data bit from the source |
| src_last | input | 1 | Marks the final bit of the packet |
| src_ready | output | 1 | High when the current bit is taken on this edge |
| line_p | output | 1 | Positive line output |
| line_n | output | 1 | Negative line output |
| line_oe | output | 1 | Line driver enable |

## Verification
The hardest case is a bit insertion that lands on the final bit of a packet. The insertion then has to come before the end marker, with no data bit still to be taken. The stimulus reaches it with packets of exactly six and twelve ones. Insertions are also placed at run lengths that are multiples of six inside a 32-bit all-ones packet. The bench decodes the line itself: it tracks level changes, strips each bit that follows six ones, and compares the result with the bits it sent. Back-to-back packets, one ending in five ones and the next starting with ones, show whether the ones count survives across packets.

// File: rtl/nrzi_stuff_tx.sv
module nrzi_stuff_tx #(
  parameter int STUFF_RUN = 6,
  parameter int SE0_LEN   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_valid,
  input  logic src_bit,
  input  logic src_last,
  output logic src_ready,
  output logic line_p,
  output logic line_n,
  output logic line_oe
);
  localparam int RW = $clog2(STUFF_RUN + 1);
  localparam int SW = $clog2(SE0_LEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_BITS, S_SE0, S_JEND} st_t;

  st_t           st;
  logic          lvl;
  logic          last_in;
  logic [RW-1:0] ones;
  logic [SW-1:0] se0_cnt;
  logic          stuff_due;

  assign stuff_due = (ones == RW'(STUFF_RUN));
  assign src_ready = (st == S_IDLE) ? 1'b1 : (st == S_BITS && !stuff_due && !last_in);
  assign line_oe   = (st != S_IDLE);
  assign line_p    = (st == S_BITS) ? lvl : (st != S_SE0);
  assign line_n    = (st == S_BITS) ? ~lvl : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      lvl     <= 1'b1;
      last_in <= 1'b0;
      ones    <= '0;
      se0_cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (src_valid) begin
          st      <= S_BITS;
          lvl     <= src_bit;
          ones    <= src_bit ? RW'(1) : '0;
          last_in <= src_last;
        end
        S_BITS: begin
          if (stuff_due) begin
            lvl  <= ~lvl;
            ones <= '0;
          end else if (last_in) begin
            st      <= S_SE0;
            se0_cnt <= SW'(1);
          end else begin
            lvl     <= src_bit ? lvl : ~lvl;
            ones    <= src_bit ? ones + 1'b1 : '0;
            last_in <= src_last;
          end
        end
        S_SE0: begin
          if (se0_cnt == SW'(SE0_LEN)) st <= S_JEND;
          else se0_cnt <= se0_cnt + 1'b1;
        end
        default: begin
          st      <= S_IDLE;
          lvl     <= 1'b1;
          ones    <= '0;
          last_in <= 1'b0;
        end
      endcase
    end
  end

  // R3
  zero_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BITS && src_ready && !src_bit) |=> (line_p != $past(line_p)));
  // R3
  one_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BITS && src_ready && src_bit) |=> (line_p == $past(line_p)));
  // R5
  stuff_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BITS && stuff_due) |=> (line_p != $past(line_p) && line_oe));
  // R7
  pair_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_p || line_n) |-> (line_p != line_n));
  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> (line_p && !line_n && src_ready));
  // R8
  eop_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SE0 && se0_cnt == SW'(SE0_LEN)) |=> (line_oe && line_p && !line_n) ##1 !line_oe);
endmodule

// File: tb/nrzi_stuff_tx_tb.sv
module nrzi_stuff_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_valid = 1'b0;
  logic src_bit = 1'b0;
  logic src_last = 1'b0;
  logic src_ready, line_p, line_n, line_oe;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  nrzi_stuff_tx u_dut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_bit(src_bit),
    .src_last(src_last), .src_ready(src_ready), .line_p(line_p),
    .line_n(line_n), .line_oe(line_oe)
  );

  // {data (LSB sent first), length, expected inserted zeros}
  localparam logic [40:0] VEC [14] = '{
    {32'h0000_00A5, 6'd8,  3'd0},
    {32'h0000_00FF, 6'd8,  3'd1},
    {32'h0000_003F, 6'd6,  3'd1},
    {32'h0000_001F, 6'd5,  3'd0},
    {32'h0000_0007, 6'd3,  3'd0},
    {32'h0000_001F, 6'd6,  3'd0},
    {32'h0000_0FFF, 6'd12, 3'd2},
    {32'h0000_1FFF, 6'd13, 3'd2},
    {32'h0000_0FDF, 6'd12, 3'd1},
    {32'h0000_0000, 6'd8,  3'd0},
    {32'h0000_0000, 6'd1,  3'd0},
    {32'h0000_0001, 6'd1,  3'd0},
    {32'hFFFF_FFFF, 6'd32, 3'd5},
    {32'h0000_007F, 6'd7,  3'd1}
  };

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run_pkt(input logic [31:0] d, input int len, input int exp_st);
    int idx = 0, run = 0, nstuff = 0, ndec = 0, se0c = 0, jc = 0;
    int comp_bad = 0, rdy_bad = 0, tail_bad = 0, stuff_bad = 0;
    logic prev = 1'b1;
    logic [31:0] dec = '0;
    bit rdy, b, started = 0, done = 0;
    src_valid = 1'b1;
    src_bit   = d[0];
    src_last  = (len == 1);
    for (int cyc = 0; cyc < 200 && !done; cyc++) begin
      rdy = src_ready;
      @(posedge clk);
      if (rdy && (src_valid || started)) idx++;
      @(negedge clk);
      if (line_oe) begin
        if (!started) begin
          started = 1;
          chk(cyc == 0, "R4 latency", cyc, 0);
        end
        if (idx == len && src_ready) tail_bad++;
        if (!line_p && !line_n) se0c++;
        else if (se0c == 0) begin
          b = (line_p == prev);
          prev = line_p;
          if (run == 6) begin
            if (b) stuff_bad++;
            nstuff++;
            run = 0;
          end else begin
            if (ndec < 32) dec[ndec] = b;
            ndec++;
            run = b ? run + 1 : 0;
            if (run == 6 && src_ready) rdy_bad++;
          end
        end else if (line_p && !line_n) jc++;
        if ((line_p || line_n) && (line_p == line_n)) comp_bad++;
      end else if (started) begin
        done = 1;
        chk(line_p && !line_n && src_ready, "R2 idle after packet", {line_p, line_n}, 2);
      end
      src_valid = (idx < len);
      src_bit   = (idx < 32) ? d[idx] : 1'b0;
      src_last  = (idx == len - 1);
    end
    chk(done, "R8 packet completes", done, 1);
    chk(idx == len, "R4 bits consumed", idx, len);
    chk(ndec == len, "R3 decoded count", ndec, len);
    chk(dec == d, "R3 decoded data", dec, d);
    chk(nstuff == exp_st, "R5 R6 R9 inserted zeros", nstuff, exp_st);
    chk(stuff_bad == 0, "R5 inserted bit is a transition", stuff_bad, 0);
    chk(rdy_bad == 0, "R5 stall before insertion", rdy_bad, 0);
    chk(se0c == 2, "R8 both-low bit times", se0c, 2);
    chk(jc == 1, "R8 trailing idle-level bit", jc, 1);
    chk(comp_bad == 0, "R7 complementary pair", comp_bad, 0);
    chk(tail_bad == 0, "R10 ready low after last bit", tail_bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!line_oe && line_p && !line_n && src_ready, "R1 reset state",
        {line_oe, line_p, line_n, src_ready}, 4'b0101);
    rst_n = 1'b1;
    // R2: bits offered without valid must not start a packet
    src_bit = 1'b0;
    src_last = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!line_oe && line_p && !line_n, "R2 idle without valid",
          {line_oe, line_p, line_n}, 3'b010);
    end
    foreach (VEC[i]) begin
      run_pkt(VEC[i][40:9], int'(VEC[i][8:3]), int'(VEC[i][2:0]));
      @(negedge clk);
    end
    // R9: packet ending on five ones, then one of five ones directly after
    run_pkt(32'h1F, 5, 0);
    run_pkt(32'h1F, 5, 0);
    // R1: reset in mid packet returns to idle
    src_valid = 1'b1;
    src_bit = 1'b0;
    src_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    src_valid = 1'b0;
    @(negedge clk);
    chk(!line_oe && line_p && !line_n && src_ready, "R1 reset mid packet",
        {line_oe, line_p, line_n, src_ready}, 4'b0101);
    rst_n = 1'b1;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule